// File: doc/BRIEF.md
# Draw-Mode and Colour Register Unit

This unit sits in front of a pixel drawing engine and holds the state that software loads before a draw: a 32-bit mode word split into plane, depth, packing, byte-order, colour-mode, blend-factor and logic-op fields, and the working colour. Writes arrive on a 64-bit bus that has separate enables for the upper and lower 32-bit lanes. A register select picks the target word. Every decoded field and colour value is driven straight out as a registered output, ready for the rasteriser.

From the plane code, the depth and the double-buffer bit, the unit also works out how far pixel data is shifted when it is stored into the second buffer. The colour word carries two registers. The upper lane holds a full-precision red value. The lower lane holds a packed colour. How these two writes affect the fixed-point red, green and blue registers, and the colour index, depends on whether the mode word selects RGB or colour-index operation. Each fixed-point colour register has a "current" copy that is reloaded whenever its base register is written.

Top module: `drawmode_color_regs`

## Requirements
- R1: After reset every output is zero.
- R2: A lower-lane write with `wr_sel`=0 loads the mode word. The outputs are: plane from bits 2:0, depth from 4:3, double-buffer select from 5, packed from 7, byte swap from 11, RGB mode from 15, destination factor from 24:22 and logic op from 31:28. They are visible in the cycle after the write edge.
- R3: `store_shift` is 0 when double-buffer select is clear. When it is set, the value depends on the plane code. Plane 4 gives 8 at any depth. Planes 1, 2, 5 and 6 give 8 at depth 1 and 12 at depth 2. Every other case gives 0: planes 0, 3 and 7, and depths 0 and 3.
- R4: An upper-lane write with `wr_sel`=1 loads `red` and `cur_red` with `wdata[55:32]`.
- R5: On that upper-lane write with RGB mode clear, `color_idx` is loaded zero-extended from the write data. Depth 0 takes `wdata[46:43]`, depth 1 takes `wdata[50:43]` and depth 2 takes `wdata[52:41]`. At depth 3 the index keeps its value.
- R6: With RGB mode set, an upper-lane colour write leaves `color_idx` unchanged.
- R7: A lower-lane write with `wr_sel`=1 loads `color_idx` with `wdata[31:0]`.
- R8: With RGB mode set, that lower-lane write also updates the colour registers. `red` and `cur_red` get `wdata[7:0]` at bits 18:11. `green` and `cur_green` get `wdata[15:8]` at bits 18:11. `blue` and `cur_blue` get `wdata[23:16]` at bits 18:11. All other bits are zero.
- R9: With RGB mode clear, a lower-lane colour write leaves red, green and blue unchanged.
- R10: A disabled lane has no effect on any output, and neither has a `wr_sel` value of 2 or 3. Neither has an upper-lane write when `wr_sel` is 0.
- R11: When both lanes write the colour word in the same cycle, the lower lane decides `color_idx`. In RGB mode the lower lane also decides `red`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_sel | input | 2 | Register select: 0 mode word, 1 colour word |
| wr_hi | input | 1 | Upper lane enable (bits 63:32) |
| wr_lo | input | 1 | Lower lane enable (bits 31:0) |
| wdata | input | 64 | Write data |
| plane_en | output | 3 | Plane code |
| plane_depth | output | 2 | Depth code (0:4, 1:8, 2:12, 3:24 bpp) |
| dbuf_sel | output | 1 | Double-buffer select |
| packed_rw | output | 1 | Packed host transfers |
| byte_swap | output | 1 | Host byte swap |
| rgb_mode | output | 1 | RGB (1) or colour-index (0) operation |
| dst_factor | output | 3 | Destination blend factor |
| logic_op | output | 4 | Logic operation |
| store_shift | output | 4 | Second-buffer store shift |
| red | output | 24 | Fixed-point red |
| green | output | 24 | Fixed-point green |
| blue | output | 24 | Fixed-point blue |
| cur_red | output | 24 | Current red |
| cur_green | output | 24 | Current green |
| cur_blue | output | 24 | Current blue |
| color_idx | output | 32 | Colour index |

## Verification
The red write on the upper lane and the packed colour write on the lower lane share one address. One write cycle can therefore update `red` and `color_idx` from both lanes at once. The bench provokes this with both lane enables set on the colour word, once in RGB mode and once in index mode. Each time the upper-lane data is chosen so that it would give a different `red` or index than the lower lane. The scoreboard expects the lower-lane value for the index in both modes and for `red` in RGB mode. In index mode it expects the upper-lane red.

// File: rtl/drawmode_pkg.sv
package drawmode_pkg;

  localparam int SEL_W     = 2;
  localparam int SEL_MODE  = 0;
  localparam int SEL_COLOR = 1;

  typedef struct packed {
    logic [3:0] lop;
    logic [2:0] dst;
    logic       rgb;
    logic       swap;
    logic       packd;
    logic       dbuf;
    logic [1:0] depth;
    logic [2:0] plane;
  } mode_t;

  // second-buffer shift selected by plane, depth and buffer bit
  function automatic logic [3:0] store_shift_of(logic [2:0] plane,
                                                logic [1:0] depth,
                                                logic       dbuf);
    logic [3:0] s;
    s = 4'd0;
    if (dbuf) begin
      case (plane)
        3'd4: s = 4'd8;
        3'd1, 3'd2, 3'd5, 3'd6: begin
          case (depth)
            2'd1:    s = 4'd8;
            2'd2:    s = 4'd12;
            default: s = 4'd0;
          endcase
        end
        default: s = 4'd0;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/drawmode_decoder.sv
module drawmode_decoder
  import drawmode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word,
  output mode_t       mode,
  output logic [3:0]  store_shift
);

  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (load) begin
      mode_d.plane = word[2:0];
      mode_d.depth = word[4:3];
      mode_d.dbuf  = word[5];
      mode_d.packd = word[7];
      mode_d.swap  = word[11];
      mode_d.rgb   = word[15];
      mode_d.dst   = word[24:22];
      mode_d.lop   = word[31:28];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (load) mode_q <= mode_d;
  end

  assign mode        = mode_q;
  assign store_shift = store_shift_of(mode_q.plane, mode_q.depth, mode_q.dbuf);

  logic unused_mode_bits;
  assign unused_mode_bits = ^{word[6], word[10:8], word[14:12], word[21:16], word[27:25]};

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode.lop == $past(word[31:28])) && (mode.plane == $past(word[2:0])));

  // R3
  shift_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.dbuf |-> store_shift == 4'd0);

  // R3
  shift_overlay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.dbuf && mode.plane == 3'd4) |-> store_shift == 4'd8);

endmodule

// File: rtl/color_regs.sv
module color_regs #(
  parameter int COLOR_W = 24,
  parameter int IDX_W   = 32,
  parameter int FRAC_SH = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_full,
  input  logic               ld_packed,
  input  logic [31:0]        hi_word,
  input  logic [31:0]        lo_word,
  input  logic               rgb_mode,
  input  logic [1:0]         depth,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue,
  output logic [COLOR_W-1:0] cur_red,
  output logic [COLOR_W-1:0] cur_green,
  output logic [COLOR_W-1:0] cur_blue,
  output logic [IDX_W-1:0]   color_idx
);

  logic [COLOR_W-1:0] r_q, g_q, b_q, cr_q, cg_q, cb_q;
  logic [COLOR_W-1:0] r_d, g_d, b_d;
  logic [IDX_W-1:0]   i_q, i_d;
  logic               rgb_en, en;

  function automatic logic [COLOR_W-1:0] frac(logic [7:0] v);
    logic [COLOR_W-1:0] t;
    t = '0;
    t[FRAC_SH +: 8] = v;
    return t;
  endfunction

  assign rgb_en = ld_packed && rgb_mode;
  assign en     = ld_full || ld_packed;

  // next state: upper lane first, lower lane overrides
  always_comb begin
    r_d = r_q;
    g_d = g_q;
    b_d = b_q;
    i_d = i_q;
    if (ld_full) begin
      r_d = hi_word[COLOR_W-1:0];
      if (!rgb_mode) begin
        case (depth)
          2'd0:    i_d = IDX_W'(hi_word[14:11]);
          2'd1:    i_d = IDX_W'(hi_word[18:11]);
          2'd2:    i_d = IDX_W'(hi_word[20:9]);
          default: i_d = i_q;
        endcase
      end
    end
    if (ld_packed) begin
      i_d = IDX_W'(lo_word);
      if (rgb_mode) begin
        r_d = frac(lo_word[7:0]);
        g_d = frac(lo_word[15:8]);
        b_d = frac(lo_word[23:16]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q  <= '0;
      cr_q <= '0;
      i_q  <= '0;
    end else if (en) begin
      r_q  <= r_d;
      cr_q <= r_d;
      i_q  <= i_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q  <= '0;
      b_q  <= '0;
      cg_q <= '0;
      cb_q <= '0;
    end else if (rgb_en) begin
      g_q  <= g_d;
      b_q  <= b_d;
      cg_q <= g_d;
      cb_q <= b_d;
    end
  end

  assign red       = r_q;
  assign green     = g_q;
  assign blue      = b_q;
  assign cur_red   = cr_q;
  assign cur_green = cg_q;
  assign cur_blue  = cb_q;
  assign color_idx = i_q;

  logic unused_hi_bits;
  assign unused_hi_bits = ^hi_word[31:COLOR_W];

  // R4
  red_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_full && !rgb_en) |=> red == $past(hi_word[COLOR_W-1:0]));

  // R7
  idx_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_packed |=> color_idx == $past(lo_word));

  // R9
  rgb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_packed && !rgb_mode) |=> $stable(green) && $stable(blue));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(red) && $stable(color_idx) && $stable(cur_red));

endmodule

// File: rtl/drawmode_color_regs.sv
module drawmode_color_regs
  import drawmode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  wr_sel,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic [63:0] wdata,
  output logic [2:0]  plane_en,
  output logic [1:0]  plane_depth,
  output logic        dbuf_sel,
  output logic        packed_rw,
  output logic        byte_swap,
  output logic        rgb_mode,
  output logic [2:0]  dst_factor,
  output logic [3:0]  logic_op,
  output logic [3:0]  store_shift,
  output logic [23:0] red,
  output logic [23:0] green,
  output logic [23:0] blue,
  output logic [23:0] cur_red,
  output logic [23:0] cur_green,
  output logic [23:0] cur_blue,
  output logic [31:0] color_idx
);

  // asynchronous assert, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic  ld_mode, ld_full, ld_packed;
  mode_t mode;

  assign ld_mode   = wr_lo && (wr_sel == SEL_W'(SEL_MODE));
  assign ld_full   = wr_hi && (wr_sel == SEL_W'(SEL_COLOR));
  assign ld_packed = wr_lo && (wr_sel == SEL_W'(SEL_COLOR));

  drawmode_decoder u_mode (
    .clk         (clk),
    .rst_n       (rst_sync),
    .load        (ld_mode),
    .word        (wdata[31:0]),
    .mode        (mode),
    .store_shift (store_shift)
  );

  color_regs #(.COLOR_W(24), .IDX_W(32), .FRAC_SH(11)) u_color (
    .clk       (clk),
    .rst_n     (rst_sync),
    .ld_full   (ld_full),
    .ld_packed (ld_packed),
    .hi_word   (wdata[63:32]),
    .lo_word   (wdata[31:0]),
    .rgb_mode  (mode.rgb),
    .depth     (mode.depth),
    .red       (red),
    .green     (green),
    .blue      (blue),
    .cur_red   (cur_red),
    .cur_green (cur_green),
    .cur_blue  (cur_blue),
    .color_idx (color_idx)
  );

  assign plane_en    = mode.plane;
  assign plane_depth = mode.depth;
  assign dbuf_sel    = mode.dbuf;
  assign packed_rw   = mode.packd;
  assign byte_swap   = mode.swap;
  assign rgb_mode    = mode.rgb;
  assign dst_factor  = mode.dst;
  assign logic_op    = mode.lop;

  // R11
  both_lanes_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (ld_full && ld_packed) |=> color_idx == $past(wdata[31:0]));

  // R6
  rgb_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (ld_full && !ld_packed && rgb_mode && !ld_mode) |=> $stable(color_idx));

endmodule

// File: tb/test_drawmode_color_regs.sv
module test_drawmode_color_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic [63:0] wdata = '0;
  logic [2:0]  plane_en;
  logic [1:0]  plane_depth;
  logic        dbuf_sel, packed_rw, byte_swap, rgb_mode;
  logic [2:0]  dst_factor;
  logic [3:0]  logic_op, store_shift;
  logic [23:0] red, green, blue, cur_red, cur_green, cur_blue;
  logic [31:0] color_idx;

  always #5 clk = ~clk;

  drawmode_color_regs i_drawmode_color_regs (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wdata(wdata), .plane_en(plane_en), .plane_depth(plane_depth),
    .dbuf_sel(dbuf_sel), .packed_rw(packed_rw), .byte_swap(byte_swap),
    .rgb_mode(rgb_mode), .dst_factor(dst_factor), .logic_op(logic_op),
    .store_shift(store_shift), .red(red), .green(green), .blue(blue),
    .cur_red(cur_red), .cur_green(cur_green), .cur_blue(cur_blue),
    .color_idx(color_idx)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] em = '0;
  logic [23:0] er = '0, eg = '0, eb = '0;
  logic [31:0] ei = '0;

  logic [195:0] exp_q[$];
  string        tag_q[$];

  function automatic logic [3:0] exp_shift(logic [31:0] m);
    if (!m[5]) return 4'd0;
    if (m[2:0] == 3'd4) return 4'd8;
    if (m[2:0] inside {3'd1, 3'd2, 3'd5, 3'd6}) begin
      if (m[4:3] == 2'd1) return 4'd8;
      if (m[4:3] == 2'd2) return 4'd12;
    end
    return 4'd0;
  endfunction

  function automatic logic [195:0] model_vec();
    return {em[2:0], em[4:3], em[5], em[7], em[11], em[15], em[24:22], em[31:28],
            exp_shift(em), er, eg, eb, er, eg, eb, ei};
  endfunction

  function automatic logic [195:0] dut_vec();
    return {plane_en, plane_depth, dbuf_sel, packed_rw, byte_swap, rgb_mode,
            dst_factor, logic_op, store_shift, red, green, blue,
            cur_red, cur_green, cur_blue, color_idx};
  endfunction

  function automatic logic [31:0] mw(logic [2:0] pl, logic [1:0] dp, logic db, logic rgb);
    logic [31:0] w;
    w = '0;
    w[2:0] = pl; w[4:3] = dp; w[5] = db; w[15] = rgb;
    return w;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic hi, input logic lo,
                    input logic [63:0] d, input string tag);
    logic rgb;
    @(negedge clk);
    wr_sel = sel; wr_hi = hi; wr_lo = lo; wdata = d;
    rgb = em[15];
    if (sel == 2'd0 && lo) em = d[31:0];
    if (sel == 2'd1) begin
      if (hi) begin
        er = d[55:32];
        if (!rgb) begin
          case (em[4:3])
            2'd0: ei = {28'd0, d[46:43]};
            2'd1: ei = {24'd0, d[50:43]};
            2'd2: ei = {20'd0, d[52:41]};
            default: ;
          endcase
        end
      end
      if (lo) begin
        ei = d[31:0];
        if (rgb) begin
          er = {5'd0, d[7:0], 11'd0};
          eg = {5'd0, d[15:8], 11'd0};
          eb = {5'd0, d[23:16], 11'd0};
        end
      end
    end
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
  endtask

  // monitor: compares one expected item per write, after the capturing edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [195:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (dut_vec() !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, dut_vec(), e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (dut_vec() !== '0) begin
      failures++;
      $display("FAIL R1 actual=%h expected=0", dut_vec());
    end

    // R2 full field decode
    wr(2'd0, 1'b0, 1'b1, 64'h0000_0000_A54F_88BD, "R2 mode fields");
    // R3 store shift table
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd1, 2'd1, 1'b1, 1'b0)}, "R3 ci 8bpp buf1");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd2, 2'd2, 1'b1, 1'b0)}, "R3 rgba 12bpp buf1");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd4, 2'd0, 1'b1, 1'b0)}, "R3 overlay 4bpp buf1");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd5, 2'd3, 1'b1, 1'b0)}, "R3 popup 24bpp buf1");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd0, 2'd1, 1'b1, 1'b0)}, "R3 none plane");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd7, 2'd2, 1'b1, 1'b0)}, "R3 invalid plane");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd6, 2'd2, 1'b0, 1'b0)}, "R3 buf0");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd6, 2'd1, 1'b1, 1'b0)}, "R3 cid 8bpp buf1");

    // R4 R5 index-mode red writes at each depth
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd1, 2'd0, 1'b0, 1'b0)}, "R2 depth0");
    wr(2'd1, 1'b1, 1'b0, {8'h00, 24'h1F_F8_AB, 32'h0}, "R4 R5 depth0 index");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd1, 2'd1, 1'b0, 1'b0)}, "R2 depth1");
    wr(2'd1, 1'b1, 1'b0, {8'h77, 24'h0A_5C_3E, 32'h0}, "R4 R5 depth1 index");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd1, 2'd2, 1'b0, 1'b0)}, "R2 depth2");
    wr(2'd1, 1'b1, 1'b0, {8'h00, 24'hFE_DC_BA, 32'h0}, "R4 R5 depth2 index");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd1, 2'd3, 1'b0, 1'b0)}, "R2 depth3");
    wr(2'd1, 1'b1, 1'b0, {8'h00, 24'h12_34_56, 32'h0}, "R5 depth3 index kept");

    // R7 R9 packed write in index mode
    wr(2'd1, 1'b0, 1'b1, {32'hFFFF_FFFF, 32'hC3A5_9601}, "R7 R9 packed ci");

    // R6 R8 RGB mode
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd2, 2'd2, 1'b0, 1'b1)}, "R2 rgb on");
    wr(2'd1, 1'b1, 1'b0, {8'h00, 24'hAB_CD_EF, 32'h0}, "R4 R6 rgb red keeps index");
    wr(2'd1, 1'b0, 1'b1, {32'h0, 32'h80FF_7F01}, "R7 R8 packed rgb expand");

    // R10 ignored writes
    wr(2'd1, 1'b0, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF}, "R10 no lanes");
    wr(2'd2, 1'b1, 1'b1, {64'h1111_1111_2222_2222}, "R10 unused select 2");
    wr(2'd3, 1'b1, 1'b1, {64'h3333_3333_4444_4444}, "R10 unused select 3");
    wr(2'd0, 1'b1, 1'b0, {64'h5555_5555_0000_0000}, "R10 mode upper lane");

    // R11 both lanes
    wr(2'd1, 1'b1, 1'b1, {8'h00, 24'h77_66_55, 32'h0012_3456}, "R11 both lanes rgb");
    wr(2'd0, 1'b0, 1'b1, {32'd0, mw(3'd1, 2'd1, 1'b0, 1'b0)}, "R2 rgb off");
    wr(2'd1, 1'b1, 1'b1, {8'h00, 24'h0F_F8_00, 32'hDEAD_BEEF}, "R11 both lanes ci");

    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule